// File: doc/BRIEF.md
# Bunch crossing tick and turn stamp counter

This block numbers beam crossings. A tick count steps once for every crossing that is flagged on the crossing-advance input. Each time the tick count rolls over, a turn count steps with it, so every crossing gets a {turn, tick} pair. A synchronous initialize input restarts the numbering from zero. This lets every copy of the counter in a system agree on crossing numbers after an initialize event. Four programmable tick-select comparators each raise their own output bit during the crossing whose tick equals their stored value. Trigger logic downstream uses these bits as timing terms.

When an accept strobe arrives, the block records the {turn, tick} pair present in that cycle. The pair travels down a delay line together with the strobe. After a programmable number of clock cycles it is written into a 16-entry first-in first-out store. A later decision stage pops the pairs back out in the order the accepts occurred. The counts and the comparator bits are also presented together as one packed 32-bit status word.

Top module: `xs_stamp_counter`

## Requirements
- R1: While init_i is low, the tick count (status_o[7:0]) rises by one on each clock edge where xing_i is high and holds otherwise; it wraps from 255 to 0.
- R2: The turn count (status_o[31:16]) rises by one on exactly those edges where the tick wraps from its maximum to 0, and itself wraps from its maximum to 0.
- R3: An edge with init_i high sets tick and turn to 0 and clears the overflow flag, whatever xing_i is; the next advancing edge then gives tick 1.
- R4: Comparator k (k = 0..3) holds an 8-bit value, 0 after reset, that is loaded from sel_value_i on an edge with sel_load_i[k] high. Its output bit is high exactly while the tick count equals that value.
- R5: status_o carries tick in bits 7:0, comparator k in bit 8+k, zeros in bits 15:12 and turn in bits 31:16.
- R6: An accept_i pulse captures the {turn, tick} pair of its own cycle, with tick in bits 7:0 and turn in bits 23:8. The pair is written to the store STROBE_DLY clock edges later.
- R7: The store holds up to 16 pairs. fifo_empty_o is high with no entries, fifo_full_o is high with 16 entries, and pairs leave in the order they were written.
- R8: A delayed write that arrives while the store is full is discarded and sets fifo_ovf_o. The flag stays set until init_i or reset clears it.
- R9: pop_i while the store is not empty moves the oldest pair to stamp_o on that edge. pop_i while the store is empty leaves stamp_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous restart of the numbering |
| xing_i | input | 1 | Advance the tick count on this edge |
| sel_load_i | input | 4 | Per-comparator load strobes |
| sel_value_i | input | 8 | Value loaded into the selected comparators |
| accept_i | input | 1 | Accept strobe to be time-stamped |
| pop_i | input | 1 | Read strobe for the oldest stored pair |
| status_o | output | 32 | Packed tick, comparator bits and turn |
| stamp_o | output | 24 | Last popped {turn, tick} pair |
| fifo_full_o | output | 1 | Store holds 16 pairs |
| fifo_empty_o | output | 1 | Store holds no pairs |
| fifo_ovf_o | output | 1 | Sticky: an accept was dropped on a full store |

## Verification
The situation hardest to reach from the ports is the turn count wrapping from its maximum back to zero. At full width that takes more than sixteen million crossings. The bench therefore builds the block with a 4-bit turn count and keeps xing_i high for a few thousand cycles, so the carry chain and the turn wrap are both exercised. The overflow path is also hard to reach, because writes arrive late through a two-stage delay line. To cover it, the bench raises accept_i on every cycle with no pops until the store is full and writes are dropped. It then drains the store past empty, to show that a pop on an empty store has no effect.

// File: rtl/xs_pkg.sv
package xs_pkg;
   // fixed layout of the packed status word
   localparam int STATUS_W   = 32;
   localparam int SEL_LSB    = 8;
   localparam int SEL_MAX    = 4;
   localparam int TURN_LSB   = 16;
   localparam int TICK_MAX_W = 8;
   localparam int TURN_MAX_W = 16;
endpackage

// File: rtl/xs_counter.sv
module xs_counter #(
   parameter int TICK_W = 8,
   parameter int TURN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              adv,
   output logic [TICK_W-1:0] tick,
   output logic [TURN_W-1:0] turn
);
   logic tick_last;
   assign tick_last = (tick == {TICK_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick <= '0;
         turn <= '0;
      end else if (init) begin
         tick <= '0;
         turn <= '0;
      end else if (adv) begin
         tick <= tick + 1'b1;
         if (tick_last) turn <= turn + 1'b1;
      end
   end
endmodule

// File: rtl/xs_tick_match.sv
module xs_tick_match #(
   parameter int TICK_W  = 8,
   parameter int NUM_SEL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SEL-1:0] load,
   input  logic [TICK_W-1:0]  load_val,
   input  logic [TICK_W-1:0]  tick,
   output logic [NUM_SEL-1:0] hit
);
   for (genvar k = 0; k < NUM_SEL; k++) begin : g_cmp
      logic [TICK_W-1:0] ref_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ref_q <= '0;
         else if (load[k]) ref_q <= load_val;
      end
      assign hit[k] = (tick == ref_q);
   end
endmodule

// File: rtl/xs_strobe_delay.sv
module xs_strobe_delay #(
   parameter int W   = 24,
   parameter int DLY = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);
   initial assert (DLY >= 0) else $error("xs_strobe_delay: DLY must not be negative");

   if (DLY == 0) begin : g_pass
      assign out_vld  = in_vld;
      assign out_data = in_data;
   end else begin : g_pipe
      logic [DLY-1:0] vld_q;
      logic [W-1:0]   dat_q [DLY];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= '0;
         else begin
            vld_q[0] <= in_vld;
            for (int i = 1; i < DLY; i++) vld_q[i] <= vld_q[i-1];
         end
      end

      always_ff @(posedge clk) begin
         dat_q[0] <= in_data;
         for (int i = 1; i < DLY; i++) dat_q[i] <= dat_q[i-1];
      end

      assign out_vld  = vld_q[DLY-1];
      assign out_data = dat_q[DLY-1];
   end
endmodule

// File: rtl/xs_capture_fifo.sv
module xs_capture_fifo #(
   parameter int W     = 24,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_ovf,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty,
   output logic         ovf
);
   localparam int AW = $clog2(DEPTH);

   initial assert (DEPTH >= 2 && (1 << AW) == DEPTH)
      else $error("xs_capture_fifo: DEPTH must be a power of two, at least 2");

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   cnt;
   logic          do_wr, do_rd;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt   <= '0;
         rdata <= '0;
         ovf   <= 1'b0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) begin
            rptr  <= rptr + 1'b1;
            rdata <= mem[rptr];
         end
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (clr_ovf)        ovf <= 1'b0;
         else if (wr && full) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/xs_stamp_counter.sv
module xs_stamp_counter #(
   parameter int TICK_W     = 8,
   parameter int TURN_W     = 16,
   parameter int NUM_SEL    = 4,
   parameter int FIFO_DEPTH = 16,
   parameter int STROBE_DLY = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     init_i,
   input  logic                     xing_i,
   input  logic [NUM_SEL-1:0]       sel_load_i,
   input  logic [TICK_W-1:0]        sel_value_i,
   input  logic                     accept_i,
   input  logic                     pop_i,
   output logic [31:0]              status_o,
   output logic [TURN_W+TICK_W-1:0] stamp_o,
   output logic                     fifo_full_o,
   output logic                     fifo_empty_o,
   output logic                     fifo_ovf_o
);
   import xs_pkg::*;

   localparam int STAMP_W = TURN_W + TICK_W;

   initial begin
      assert (TICK_W >= 1 && TICK_W <= TICK_MAX_W) else $error("TICK_W out of range");
      assert (TURN_W >= 1 && TURN_W <= TURN_MAX_W) else $error("TURN_W out of range");
      assert (NUM_SEL >= 1 && NUM_SEL <= SEL_MAX)  else $error("NUM_SEL out of range");
   end

   logic [TICK_W-1:0]  tick;
   logic [TURN_W-1:0]  turn;
   logic [NUM_SEL-1:0] hit;
   logic               wr_vld;
   logic [STAMP_W-1:0] wr_pair;

   xs_counter #(.TICK_W(TICK_W), .TURN_W(TURN_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .init(init_i), .adv(xing_i),
      .tick(tick), .turn(turn)
   );

   xs_tick_match #(.TICK_W(TICK_W), .NUM_SEL(NUM_SEL)) u_match (
      .clk(clk), .rst_n(rst_n), .load(sel_load_i), .load_val(sel_value_i),
      .tick(tick), .hit(hit)
   );

   // the pair rides with the strobe, so the stored stamp is the accept cycle's
   xs_strobe_delay #(.W(STAMP_W), .DLY(STROBE_DLY)) u_dly (
      .clk(clk), .rst_n(rst_n), .in_vld(accept_i), .in_data({turn, tick}),
      .out_vld(wr_vld), .out_data(wr_pair)
   );

   xs_capture_fifo #(.W(STAMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr_ovf(init_i),
      .wr(wr_vld), .wdata(wr_pair), .rd(pop_i), .rdata(stamp_o),
      .full(fifo_full_o), .empty(fifo_empty_o), .ovf(fifo_ovf_o)
   );

   always_comb begin
      status_o = '0;
      status_o[TICK_W-1:0]          = tick;
      status_o[SEL_LSB +: NUM_SEL]  = hit;
      status_o[TURN_LSB +: TURN_W]  = turn;
   end
endmodule

// File: rtl/xs_stamp_chk.sv
module xs_stamp_chk #(
   parameter int TICK_W = 8,
   parameter int TURN_W = 16,
   parameter int STAMP_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               init_i,
   input logic               xing_i,
   input logic               pop_i,
   input logic [31:0]        status_o,
   input logic [STAMP_W-1:0] stamp_o,
   input logic               fifo_full_o,
   input logic               fifo_empty_o,
   input logic               fifo_ovf_o
);
   logic [TICK_W-1:0] tick;
   logic [TURN_W-1:0] turn;
   logic              tick_top;
   assign tick     = status_o[TICK_W-1:0];
   assign turn     = status_o[16 +: TURN_W];
   assign tick_top = (tick == {TICK_W{1'b1}});

   assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && xing_i) |=> (tick == TICK_W'($past(tick) + 1'b1)));

   assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !xing_i) |=> ($stable(tick) && $stable(turn)));

   assert_turn_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && xing_i && tick_top) |=> (turn == TURN_W'($past(turn) + 1'b1)));

   assert_turn_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && xing_i && !tick_top) |=> $stable(turn));

   assert_init_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (tick == '0 && turn == '0 && !fifo_ovf_o));

   assert_flags_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full_o && fifo_empty_o));

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_ovf_o && !init_i) |=> fifo_ovf_o);

   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && fifo_empty_o) |=> $stable(stamp_o));
endmodule

bind xs_stamp_counter xs_stamp_chk #(
   .TICK_W(TICK_W), .TURN_W(TURN_W), .STAMP_W(TURN_W + TICK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .init_i(init_i), .xing_i(xing_i), .pop_i(pop_i),
   .status_o(status_o), .stamp_o(stamp_o), .fifo_full_o(fifo_full_o),
   .fifo_empty_o(fifo_empty_o), .fifo_ovf_o(fifo_ovf_o)
);

// File: tb/xs_stamp_counter_tb.sv
module xs_stamp_counter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TB_TURN_W  = 4;   // narrowed so the turn wrap is reachable
   localparam int TB_DLY     = 2;
   localparam int DEPTH      = 16;
   localparam int SW         = TB_TURN_W + 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_i = 1'b0, xing_i = 1'b0, accept_i = 1'b0, pop_i = 1'b0;
   logic [3:0]    sel_load_i = '0;
   logic [7:0]    sel_value_i = '0;
   logic [31:0]   status_o;
   logic [SW-1:0] stamp_o;
   logic          fifo_full_o, fifo_empty_o, fifo_ovf_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xs_stamp_counter #(.TICK_W(8), .TURN_W(TB_TURN_W), .NUM_SEL(4),
                      .FIFO_DEPTH(DEPTH), .STROBE_DLY(TB_DLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .xing_i(xing_i),
      .sel_load_i(sel_load_i), .sel_value_i(sel_value_i), .accept_i(accept_i),
      .pop_i(pop_i), .status_o(status_o), .stamp_o(stamp_o),
      .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o), .fifo_ovf_o(fifo_ovf_o)
   );

   // reference model
   int            m_tick, m_turn, m_rd;
   int            m_cmp [4];
   bit            m_ovf;
   bit            p_v [TB_DLY];
   int            p_d [TB_DLY];
   int            q [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tick = 0; m_turn = 0; m_rd = 0; m_ovf = 0;
         for (int k = 0; k < 4; k++) m_cmp[k] = 0;
         for (int i = 0; i < TB_DLY; i++) begin p_v[i] = 0; p_d[i] = 0; end
         q.delete();
      end else begin
         bit wv, was_full, was_empty;
         int wd;
         wv = p_v[TB_DLY-1]; wd = p_d[TB_DLY-1];
         was_full = (q.size() == DEPTH); was_empty = (q.size() == 0);
         if (pop_i && !was_empty) m_rd = q.pop_front();
         if (wv && !was_full) q.push_back(wd);
         if (init_i) m_ovf = 0; else if (wv && was_full) m_ovf = 1;
         for (int i = TB_DLY-1; i > 0; i--) begin p_v[i] = p_v[i-1]; p_d[i] = p_d[i-1]; end
         p_v[0] = accept_i; p_d[0] = (m_turn << 8) | m_tick;
         if (init_i) begin m_tick = 0; m_turn = 0; end
         else if (xing_i) begin
            if (m_tick == 255) begin
               m_tick = 0;
               m_turn = (m_turn + 1) % (1 << TB_TURN_W);
            end else m_tick = m_tick + 1;
         end
         for (int k = 0; k < 4; k++) if (sel_load_i[k]) m_cmp[k] = sel_value_i;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) begin
         int hits, word;
         hits = 0;
         for (int k = 0; k < 4; k++) if (m_tick == m_cmp[k]) hits |= (1 << k);
         word = (m_turn << 16) | (hits << 8) | m_tick;
         chk("R1 R3 tick", int'(status_o[7:0]), m_tick);
         chk("R2 R3 turn", int'(status_o[31:16]), m_turn);
         chk("R4 tick-select bits", int'(status_o[11:8]), hits);
         chk("R5 status word", int'(status_o), word);
         chk("R6 R9 stamp", int'(stamp_o), m_rd);
         chk("R7 full flag", int'(fifo_full_o), int'(q.size() == DEPTH));
         chk("R7 empty flag", int'(fifo_empty_o), int'(q.size() == 0));
         chk("R3 R8 overflow flag", int'(fifo_ovf_o), int'(m_ovf));
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;                      // reset state compared above (R1..R9)
      step(2);
      // R4: program comparators
      sel_load_i = 4'b0001; sel_value_i = 8'd3;   step(1);
      sel_load_i = 4'b0010; sel_value_i = 8'd100; step(1);
      sel_load_i = 4'b0100; sel_value_i = 8'd255; step(1);
      sel_load_i = 4'b1000; sel_value_i = 8'd17;  step(1);
      sel_load_i = 4'b0110; sel_value_i = 8'd5;   step(1);
      sel_load_i = 4'b0000;
      // R1 R6 R9: mixed traffic
      for (int i = 0; i < 600; i++) begin
         xing_i   = ($urandom % 4) != 0;
         accept_i = ($urandom % 16) == 0;
         pop_i    = ($urandom % 8) == 0;
         step(1);
      end
      // R7 R8: fill past full with no pops
      pop_i = 0; xing_i = 1; accept_i = 1;
      step(24);
      accept_i = 0; step(4);
      // R3: init together with advance clears counts and overflow
      init_i = 1; step(1);
      init_i = 0; step(3);
      // R9: drain and pop past empty
      pop_i = 1; step(22);
      pop_i = 1; accept_i = 1; step(1);
      accept_i = 0; step(4);
      pop_i = 0;
      // R2: long run to wrap the turn count
      for (int i = 0; i < 4300; i++) begin
         xing_i = 1; accept_i = (i % 300) == 0; pop_i = (i % 150) == 0;
         step(1);
      end
      // mixed random including init and comparator reloads
      for (int i = 0; i < 3000; i++) begin
         xing_i      = ($urandom % 3) != 0;
         accept_i    = ($urandom % 6) == 0;
         pop_i       = ($urandom % 7) == 0;
         init_i      = ($urandom % 250) == 0;
         sel_load_i  = (($urandom % 40) == 0) ? 4'($urandom) : 4'b0;
         sel_value_i = 8'($urandom);
         step(1);
      end
      xing_i = 0; accept_i = 0; pop_i = 0; init_i = 0; sel_load_i = 0;
      step(5);
      finish_run();
   end
endmodule